// File: doc/BRIEF.md
# Interrupt Level and Enable Masking Unit

This unit decides, every cycle, whether a processor core may take an interrupt, and it keeps the interrupt-related status state across exception entry and exception return. Two sources are gated at once. A bank of level-sensitive internal request lines is masked by a per-line enable register. A single external request carries a requested priority level, and that level is compared against a programmable threshold held in a status register. Both paths are qualified by a global interrupt-enable bit in the same status register.

When the core enters an exception, the unit copies the status register into a saved-status register and records the interrupted program counter in a return-address register. It then closes the global enable and, if an external request is being taken, raises the threshold to that request's level. On an exception-return strobe the saved status is copied back, and the stored address is presented as the next program counter. Software changes the enable mask and the status register through a simple register-write port. This is how a handler can lower its own threshold so that a request of its own level may preempt it.

Top module: `intr_mask_unit`

## Requirements
- R1: A synchronous active-high reset clears the enable mask, the status register, the saved-status register and the return address. While no register is written, `take_irq` stays low.
- R2: The internal path requests when `(irq_lines & ienable_o)` is nonzero. Enable bit n set to 1 passes line n, and set to 0 blocks it. `take_irq` is high only while the global enable (status bit 0) is 1.
- R3: The external path requests only when `ext_req` is high and `ext_lvl` is strictly greater than the status level field (status bits 6:1). A level field of 0 passes every nonzero level. A field of 63 blocks every level.
- R4: With `wr_en` high, `wr_sel`=0 loads `wr_data` into the enable mask, and `wr_sel`=1 loads `wr_data[6:0]` into the status register. The new value, and any change of `take_irq` it causes, appears in the cycle after the write. `take_irq` is combinational from registered state and the request inputs.
- R5: On `exc_enter`, the saved status receives the current status and `resume_pc` receives `exc_pc` in the next cycle. In the same cycle the global enable clears. The level field becomes `ext_lvl` if the external path was passing, and otherwise stays unchanged.
- R6: On `exc_return` without `exc_enter`, `resume_go` is high in that same cycle with `resume_pc` holding the stored address. In the next cycle the status register equals the saved status.
- R7: When `exc_enter` and `exc_return` are high together, entry is performed and `resume_go` stays low. A register write coinciding with entry or return is ignored.
- R8: A handler that rewrites status to level 4 with the enable set is preempted by an external request of level 5, while a level 4 request stays blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_IRQ | Level-sensitive internal request lines |
| ext_req | input | 1 | External request present |
| ext_lvl | input | 6 | Level of the external request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the enable mask, 1 selects status |
| wr_data | input | NUM_IRQ | Write data |
| exc_enter | input | 1 | Exception entry strobe from the core |
| exc_pc | input | PC_W | Address of the interrupted instruction |
| exc_return | input | 1 | Exception return strobe from the core |
| take_irq | output | 1 | An interrupt may be taken now |
| resume_go | output | 1 | Redirect to `resume_pc` this cycle |
| resume_pc | output | PC_W | Stored return address |
| ienable_o | output | NUM_IRQ | Current enable mask |
| status_o | output | 7 | Current status: bit 0 global enable, bits 6:1 level |
| estatus_o | output | 7 | Saved status, same layout |

## Verification
`take_irq` and `resume_go` are combinational, so they are due in the same cycle as the inputs that drive them. The bench samples them one time unit after inputs change at the falling edge. Register writes, entry and return land at the next rising edge, so mask, status, saved status and address are checked at the following falling edge. A behavioural model, updated once per edge from the inputs it was just compared against, supplies every expected value. Directed sequences cover threshold limits, nesting and strobe collisions, and a random phase follows.

// File: rtl/intr_mask_pkg.sv
package intr_mask_pkg;
  localparam int LVL_W  = 6;
  localparam int STAT_W = LVL_W + 1;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             gie;
  } stat_t;
endpackage

// File: rtl/intr_int_gate.sv
module intr_int_gate #(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [NUM_IRQ-1:0] ien,
  output logic               int_hit
);
  logic [NUM_IRQ-1:0] masked;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign masked[i] = irq_lines[i] & ien[i];
  end

  assign int_hit = |masked;
endmodule

// File: rtl/intr_lvl_cmp.sv
module intr_lvl_cmp #(
  parameter int LVL_W = 6
) (
  input  logic             ext_req,
  input  logic [LVL_W-1:0] ext_lvl,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             ext_hit
);
  assign ext_hit = ext_req && (ext_lvl > cur_lvl);
endmodule

// File: rtl/intr_state_regs.sv
module intr_state_regs
  import intr_mask_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PC_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [NUM_IRQ-1:0] wr_data,
  input  logic               enter,
  input  logic               ret,
  input  logic               ext_take,
  input  logic [LVL_W-1:0]   ext_lvl,
  input  logic [PC_W-1:0]    pc_in,
  output logic [NUM_IRQ-1:0] ien_q,
  output stat_t              stat_q,
  output stat_t              estat_q,
  output logic [PC_W-1:0]    ea_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= '0;
      stat_q  <= '0;
      estat_q <= '0;
      ea_q    <= '0;
    end else if (enter) begin
      estat_q    <= stat_q;
      ea_q       <= pc_in;
      stat_q.gie <= 1'b0;
      if (ext_take) stat_q.lvl <= ext_lvl;
    end else if (ret) begin
      stat_q <= estat_q;
    end else if (wr_en) begin
      if (wr_sel) stat_q <= stat_t'(wr_data[STAT_W-1:0]);
      else        ien_q  <= wr_data;
    end
  end
endmodule

// File: rtl/intr_mask_unit.sv
module intr_mask_unit
  import intr_mask_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PC_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               ext_req,
  input  logic [LVL_W-1:0]   ext_lvl,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [NUM_IRQ-1:0] wr_data,
  input  logic               exc_enter,
  input  logic [PC_W-1:0]    exc_pc,
  input  logic               exc_return,
  output logic               take_irq,
  output logic               resume_go,
  output logic [PC_W-1:0]    resume_pc,
  output logic [NUM_IRQ-1:0] ienable_o,
  output logic [STAT_W-1:0]  status_o,
  output logic [STAT_W-1:0]  estatus_o
);
  stat_t stat, estat;
  logic  int_hit, ext_hit, ext_take;

  intr_int_gate #(.NUM_IRQ(NUM_IRQ)) u_int_gate (
    .irq_lines (irq_lines),
    .ien       (ienable_o),
    .int_hit   (int_hit)
  );

  intr_lvl_cmp #(.LVL_W(LVL_W)) u_lvl_cmp (
    .ext_req (ext_req),
    .ext_lvl (ext_lvl),
    .cur_lvl (stat.lvl),
    .ext_hit (ext_hit)
  );

  assign ext_take = stat.gie & ext_hit;

  intr_state_regs #(.NUM_IRQ(NUM_IRQ), .PC_W(PC_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .enter    (exc_enter),
    .ret      (exc_return),
    .ext_take (ext_take),
    .ext_lvl  (ext_lvl),
    .pc_in    (exc_pc),
    .ien_q    (ienable_o),
    .stat_q   (stat),
    .estat_q  (estat),
    .ea_q     (resume_pc)
  );

  assign take_irq  = stat.gie & (int_hit | ext_hit);
  assign resume_go = exc_return & ~exc_enter;
  assign status_o  = stat;
  assign estatus_o = estat;
endmodule

// File: rtl/intr_mask_chk.sv
module intr_mask_chk
  import intr_mask_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PC_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IRQ-1:0] irq_lines,
  input logic [NUM_IRQ-1:0] ienable_o,
  input logic               ext_req,
  input logic [LVL_W-1:0]   ext_lvl,
  input logic               exc_enter,
  input logic               exc_return,
  input logic [PC_W-1:0]    exc_pc,
  input logic               take_irq,
  input logic               resume_go,
  input logic [PC_W-1:0]    resume_pc,
  input logic [STAT_W-1:0]  status_o,
  input logic [STAT_W-1:0]  estatus_o
);
  logic int_any;
  assign int_any = |(irq_lines & ienable_o);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (status_o == '0 && ienable_o == '0 && estatus_o == '0)); // R1
  AST_GIE_GATES: assert property (@(posedge clk) disable iff (rst) !status_o[0] |-> !take_irq); // R2
  AST_EXT_STRICT: assert property (@(posedge clk) disable iff (rst) (take_irq && !int_any) |-> (ext_req && ext_lvl > status_o[LVL_W:1])); // R3
  AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (rst) exc_enter |=> (estatus_o == $past(status_o) && resume_pc == $past(exc_pc) && !status_o[0])); // R5
  AST_ENTRY_RAISES: assert property (@(posedge clk) disable iff (rst) (exc_enter && take_irq && !int_any) |=> status_o[LVL_W:1] == $past(ext_lvl)); // R5
  AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (rst) (exc_return && !exc_enter) |=> status_o == $past(estatus_o)); // R6
  AST_ENTRY_WINS: assert property (@(posedge clk) disable iff (rst) exc_enter |-> !resume_go); // R7
endmodule

bind intr_mask_unit intr_mask_chk #(.NUM_IRQ(NUM_IRQ), .PC_W(PC_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_lines  (irq_lines),
  .ienable_o  (ienable_o),
  .ext_req    (ext_req),
  .ext_lvl    (ext_lvl),
  .exc_enter  (exc_enter),
  .exc_return (exc_return),
  .exc_pc     (exc_pc),
  .take_irq   (take_irq),
  .resume_go  (resume_go),
  .resume_pc  (resume_pc),
  .status_o   (status_o),
  .estatus_o  (estatus_o)
);

// File: tb/test_intr_mask_unit.sv
module test_intr_mask_unit;
  import intr_mask_pkg::*;
  localparam int NUM_IRQ = 32;
  localparam int PC_W    = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_IRQ-1:0] irq_lines = '0;
  logic ext_req = 1'b0;
  logic [LVL_W-1:0] ext_lvl = '0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [NUM_IRQ-1:0] wr_data = '0;
  logic exc_enter = 1'b0, exc_return = 1'b0;
  logic [PC_W-1:0] exc_pc = '0;
  logic take_irq, resume_go;
  logic [PC_W-1:0] resume_pc;
  logic [NUM_IRQ-1:0] ienable_o;
  logic [STAT_W-1:0] status_o, estatus_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [NUM_IRQ-1:0] m_ien;
  logic m_gie, m_egie;
  logic [LVL_W-1:0] m_il, m_eil;
  logic [PC_W-1:0] m_ea;

  always #5 clk = ~clk;

  intr_mask_unit #(.NUM_IRQ(NUM_IRQ), .PC_W(PC_W)) i_intr_mask_unit (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .ext_req(ext_req), .ext_lvl(ext_lvl),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .exc_enter(exc_enter),
    .exc_pc(exc_pc), .exc_return(exc_return), .take_irq(take_irq), .resume_go(resume_go),
    .resume_pc(resume_pc), .ienable_o(ienable_o), .status_o(status_o), .estatus_o(estatus_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic m_ext_ok();
    return ext_req && (ext_lvl > m_il);
  endfunction

  function automatic logic m_take();
    return m_gie && ((|(irq_lines & m_ien)) || m_ext_ok());
  endfunction

  // compare against the model one unit after the falling edge, then advance the model
  task automatic step();
    #1;
    chk("R2/R3 take_irq", 64'(take_irq), 64'(m_take()));
    chk("R6 resume_go", 64'(resume_go), 64'(exc_return && !exc_enter));
    chk("R4 ienable", 64'(ienable_o), 64'(m_ien));
    chk("R4 status", 64'(status_o), 64'({m_il, m_gie}));
    chk("R5 estatus", 64'(estatus_o), 64'({m_eil, m_egie}));
    chk("R5 resume_pc", 64'(resume_pc), 64'(m_ea));
    if (rst) begin
      m_ien = '0; m_gie = 0; m_il = '0; m_egie = 0; m_eil = '0; m_ea = '0;
    end else if (exc_enter) begin
      m_egie = m_gie; m_eil = m_il; m_ea = exc_pc;
      if (m_gie && m_ext_ok()) m_il = ext_lvl;
      m_gie = 0;
    end else if (exc_return) begin
      m_gie = m_egie; m_il = m_eil;
    end else if (wr_en) begin
      if (wr_sel) begin m_gie = wr_data[0]; m_il = wr_data[LVL_W:1]; end
      else m_ien = wr_data;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; exc_enter = 0; exc_return = 0; ext_req = 0; irq_lines = '0;
  endtask

  task automatic write(logic sel, logic [NUM_IRQ-1:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic expect_take(string tag, logic exp);
    #1;
    chk(tag, 64'(take_irq), 64'(exp));
    step();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    m_ien = '0; m_gie = 0; m_il = '0; m_egie = 0; m_eil = '0; m_ea = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, all lines and top external level presented
    irq_lines = '1; ext_req = 1; ext_lvl = 6'd63;
    #1;
    chk("R1 status after reset", 64'(status_o), 64'd0);
    chk("R1 ienable after reset", 64'(ienable_o), 64'd0);
    expect_take("R1 take_irq after reset", 1'b0);
    idle();

    // R2: per-line enable
    write(1'b1, 32'h1);
    write(1'b0, 32'h20);
    irq_lines = 32'h10;
    expect_take("R2 disabled line blocked", 1'b0);
    irq_lines = 32'h20;
    expect_take("R2 enabled line taken", 1'b1);
    write(1'b0, 32'h8000_0000);
    irq_lines = 32'h8000_0000;
    expect_take("R2 line 31 taken", 1'b1);
    write(1'b1, 32'h0);
    expect_take("R2 global enable off blocks", 1'b0);
    idle();
    write(1'b0, 32'h0);

    // R3: strict level compare
    write(1'b1, 32'h1);
    ext_req = 1; ext_lvl = 6'd1;
    expect_take("R3 level 1 over threshold 0", 1'b1);
    ext_lvl = 6'd0;
    expect_take("R3 level 0 at threshold 0", 1'b0);
    write(1'b1, {25'd0, 6'd63, 1'b1});
    ext_lvl = 6'd63;
    expect_take("R3 threshold 63 blocks all", 1'b0);
    write(1'b1, {25'd0, 6'd5, 1'b1});
    ext_lvl = 6'd5;
    expect_take("R3 equal level blocked", 1'b0);
    ext_lvl = 6'd6;
    expect_take("R3 higher level taken", 1'b1);

    // R5: entry saves status and address, raises level
    write(1'b1, 32'h1);
    ext_lvl = 6'd5; exc_enter = 1; exc_pc = 32'h0000_1234;
    step();
    exc_enter = 0; ext_req = 0;
    #1;
    chk("R5 level raised, enable cleared", 64'(status_o), 64'({6'd5, 1'b0}));
    chk("R5 saved status", 64'(estatus_o), 64'({6'd0, 1'b1}));
    chk("R5 return address", 64'(resume_pc), 64'h1234);
    step();

    // R8: handler lowers threshold to 4
    write(1'b1, {25'd0, 6'd4, 1'b1});
    ext_req = 1; ext_lvl = 6'd5;
    expect_take("R8 level 5 preempts", 1'b1);
    ext_lvl = 6'd4;
    expect_take("R8 level 4 blocked", 1'b0);
    ext_req = 0;

    // R6: return restores
    exc_return = 1;
    #1;
    chk("R6 resume_go with return", 64'(resume_go), 64'd1);
    step();
    exc_return = 0;
    #1;
    chk("R6 status restored", 64'(status_o), 64'({6'd0, 1'b1}));
    step();

    // R7: entry beats return and write
    write(1'b1, {25'd0, 6'd2, 1'b1});
    exc_enter = 1; exc_return = 1; exc_pc = 32'h55;
    wr_en = 1; wr_sel = 0; wr_data = 32'hFFFF_FFFF;
    #1;
    chk("R7 no redirect when entry collides", 64'(resume_go), 64'd0);
    step();
    idle();
    #1;
    chk("R7 entry performed", 64'(status_o), 64'({6'd2, 1'b0}));
    chk("R7 saved status from entry", 64'(estatus_o), 64'({6'd2, 1'b1}));
    chk("R7 write ignored", 64'(ienable_o), 64'(m_ien));
    step();
    exc_return = 1; wr_en = 1; wr_sel = 1; wr_data = 32'h7F;
    step();
    idle();
    #1;
    chk("R7 write during return ignored", 64'(status_o), 64'({6'd2, 1'b1}));
    step();

    // random phase
    for (int i = 0; i < 2000; i++) begin
      rst        = ($urandom_range(0, 99) == 0);
      irq_lines  = ($urandom_range(0, 1) == 0) ? '0 : (32'h1 << $urandom_range(0, 31));
      ext_req    = $urandom_range(0, 1) == 1;
      ext_lvl    = LVL_W'($urandom_range(0, 63));
      wr_en      = ($urandom_range(0, 3) == 0);
      wr_sel     = $urandom_range(0, 1) == 1;
      wr_data    = $urandom;
      exc_enter  = ($urandom_range(0, 7) == 0);
      exc_return = ($urandom_range(0, 7) == 0);
      exc_pc     = $urandom;
      step();
    end
    rst = 0;
    idle();
    step();
    finish_run();
  end
endmodule